// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address of each beat of a four-beat burst into a synchronous memory array. On an address-strobe cycle it captures the whole external address. After that it steps only the two low address bits, and only in cycles where the advance input is high. The upper bits stay fixed for the rest of the burst.

The step order is chosen by an order-select input, and that input is latched at the strobe. Linear order counts upward and wraps modulo four. Interleaved order XORs the starting low bits with the beat count.

Two strobes can start a burst. The controller strobe always loads. The processor strobe loads only while the active-low primary select is low. A strobe that arrives in the middle of a burst restarts the sequence from the newly captured address.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with no strobe seen, `burst_addr` is all zeros.
- R2: A cycle with `ctrl_strobe` high loads `ext_addr` into `burst_addr` at the next rising edge, whatever the levels of `prim_sel_n`, `proc_strobe` and `advance`.
- R3: A cycle with `proc_strobe` high and `prim_sel_n` low loads `ext_addr` at the next rising edge.
- R4: A cycle with `proc_strobe` high, `prim_sel_n` high, `ctrl_strobe` low and `advance` low leaves `burst_addr` unchanged.
- R5: A cycle with no effective strobe and `advance` low leaves `burst_addr` unchanged.
- R6: When `order_sel` was 0 at the load, the low two bits after n advances equal (start + n) mod 4, where start is the low two bits that were loaded.
- R7: When `order_sel` was 1 at the load, the low two bits after n advances equal start XOR (n mod 4).
- R8: Bits above bit 1 of `burst_addr` change only at a load.
- R9: Four advances after a load return the low bits to their loaded value, in both orders.
- R10: A change of `order_sel` between loads has no effect until the next load.
- R11: A strobe in the middle of a burst restarts the beat count from zero at the new address. A strobe takes priority over `advance` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | ADDR_W | External address, captured on a strobe |
| proc_strobe | input | 1 | Processor address strobe, active high, qualified by `prim_sel_n` |
| ctrl_strobe | input | 1 | Controller address strobe, active high, unqualified |
| prim_sel_n | input | 1 | Primary select, active low; when high, `proc_strobe` is ignored |
| advance | input | 1 | Step the burst by one beat |
| order_sel | input | 1 | Burst order: 0 is linear, 1 is interleaved; latched at a load |
| burst_addr | output | ADDR_W | Current internal address |

## Verification
The hardest state to reach from the ports is a burst that was loaded in one order while `order_sel` now holds the other value. The correct sequence in that state is easy to confuse with the wrong one, because only some start values make the two orders differ. The stimulus loads under each order at every start value. It then flips `order_sel` in the middle of the burst and keeps advancing, with hold cycles mixed in. In a separate case it fires strobes in the same cycle as `advance`, so that load priority and restart are observed on the address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int unsigned BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  // Low bits for linear order: start plus beat, wrapping
  function automatic beat_t lin_offset(input beat_t start, input beat_t beat);
    return beat_t'(start + beat);
  endfunction

  // Low bits for interleaved order: start XOR beat
  function automatic beat_t xor_offset(input beat_t start, input beat_t beat);
    return start ^ beat;
  endfunction

  function automatic beat_t order_offset(input order_e ord, input beat_t start,
                                         input beat_t beat);
    return (ord == ORD_XOR) ? xor_offset(start, beat) : lin_offset(start, beat);
  endfunction

endpackage

// File: rtl/burst_load_qual.sv
module burst_load_qual (
  input  logic proc_strobe,
  input  logic ctrl_strobe,
  input  logic prim_sel_n,
  output logic proc_load,
  output logic load
);
  // The processor strobe counts only while the primary select is active (low)
  assign proc_load = proc_strobe & ~prim_sel_n;
  assign load      = ctrl_strobe | proc_load;
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  advance,
  output beat_t beat,
  output logic  step
);
  // A load takes priority over an advance in the same cycle
  assign step = advance & ~load;

  always_ff @(posedge clk) begin
    if (!rst_n)    beat <= '0;
    else if (load) beat <= '0;
    else if (step) beat <= beat_t'(beat + 1'b1);
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] base,
  output order_e            ord_q
);
  // Holds the captured address and the order latched with it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base  <= '0;
      ord_q <= ORD_LINEAR;
    end else if (load) begin
      base  <= ext_addr;
      ord_q <= order_e'(order_sel);
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              proc_strobe,
  input  logic              ctrl_strobe,
  input  logic              prim_sel_n,
  input  logic              advance,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] burst_addr
);
  localparam int unsigned UPPER_W = ADDR_W - BEAT_W;

  // Named internal events, visible to the bound checker
  logic              load;
  logic              proc_load;
  logic              step;
  beat_t             beat;
  logic [ADDR_W-1:0] base;
  order_e            ord_q;
  beat_t             start_lo;
  beat_t             lo_bits;

  burst_load_qual u_qual (
    .proc_strobe (proc_strobe),
    .ctrl_strobe (ctrl_strobe),
    .prim_sel_n  (prim_sel_n),
    .proc_load   (proc_load),
    .load        (load)
  );

  burst_beat_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .advance (advance),
    .beat    (beat),
    .step    (step)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .ext_addr  (ext_addr),
    .order_sel (order_sel),
    .base      (base),
    .ord_q     (ord_q)
  );

  assign start_lo = base[BEAT_W-1:0];
  assign lo_bits  = order_offset(ord_q, start_lo, beat);

  if (UPPER_W > 0) begin : g_upper
    assign burst_addr = {base[ADDR_W-1:BEAT_W], lo_bits};
  end else begin : g_narrow
    assign burst_addr = lo_bits;
  end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              ctrl_strobe,
  input logic              proc_strobe,
  input logic              prim_sel_n,
  input logic              advance,
  input logic              load,
  input logic              step,
  input order_e            ord_q,
  input logic [ADDR_W-1:0] burst_addr
);
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_strobe |=> burst_addr == $past(ext_addr)); // R2
  AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe && !prim_sel_n) |=> burst_addr == $past(ext_addr)); // R3
  AST_PROC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strobe && prim_sel_n && !ctrl_strobe && !advance) |=> $stable(burst_addr)); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(burst_addr)); // R5
  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ord_q == ORD_LINEAR) |=>
      burst_addr[BEAT_W-1:0] == beat_t'($past(burst_addr[BEAT_W-1:0]) + 1'b1)); // R6
  AST_ADV_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> burst_addr[BEAT_W-1:0] != $past(burst_addr[BEAT_W-1:0])); // R7
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> burst_addr[ADDR_W-1:BEAT_W] == $past(burst_addr[ADDR_W-1:BEAT_W])); // R8
  AST_ORDER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ord_q)); // R10
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ext_addr    (ext_addr),
  .ctrl_strobe (ctrl_strobe),
  .proc_strobe (proc_strobe),
  .prim_sel_n  (prim_sel_n),
  .advance     (advance),
  .load        (load),
  .step        (step),
  .ord_q       (ord_q),
  .burst_addr  (burst_addr)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int unsigned AW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ext_addr;
  logic          proc_strobe, ctrl_strobe, prim_sel_n, advance, order_sel;
  logic [AW-1:0] burst_addr;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .proc_strobe(proc_strobe),
    .ctrl_strobe(ctrl_strobe), .prim_sel_n(prim_sel_n), .advance(advance),
    .order_sel(order_sel), .burst_addr(burst_addr)
  );

  // Expected address from the requirements: R6 linear, R7 interleaved
  function automatic logic [AW-1:0] model(input logic [AW-1:0] a, input int n,
                                          input bit ilv);
    int s;
    int lo;
    s  = int'(a[1:0]);
    lo = ilv ? (s ^ (n % 4)) : ((s + n) % 4);
    return {a[AW-1:2], 2'(lo)};
  endfunction

  task automatic check(input logic [AW-1:0] exp, input string req);
    n_vec++;
    if (burst_addr !== exp) begin
      n_bad++;
      $display("FAIL %s: burst_addr=%h expected=%h", req, burst_addr, exp);
    end
  endtask

  task automatic idle();
    proc_strobe = 0; ctrl_strobe = 0; advance = 0;
  endtask

  // Inputs change just after a falling edge; one rising edge passes before sampling
  task automatic tick();
    @(negedge clk);
  endtask

  initial begin : watchdog
    #1000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    logic [AW-1:0] a;
    logic [AW-1:0] b;
    int n;
    rst_n = 0; ext_addr = '0; prim_sel_n = 0; order_sel = 0; idle();
    repeat (3) tick();
    check('0, "R1");
    rst_n = 1; tick();
    check('0, "R1");

    // Sweep: every order, every start, both strobes, with hold cycles in between
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int via = 0; via < 2; via++) begin
          a = {18'(m * 5003 + s * 977 + via * 131 + 7), 2'(s)};
          ext_addr = a; order_sel = m[0]; prim_sel_n = 0;
          if (via == 0) ctrl_strobe = 1; else proc_strobe = 1;
          tick(); idle();
          check(a, via == 0 ? "R2" : "R3");
          n = 0;
          for (int k = 0; k < 9; k++) begin
            advance = (k % 3 != 2);
            ext_addr = ~a;
            if (k == 4) order_sel = ~order_sel;
            tick();
            if (advance) n++;
            check(model(a, n, m != 0), m != 0 ? "R7 R10 R8" : "R6 R10 R8");
            if (n == 4 && advance) check(a, "R9");
            advance = 0; tick();
            check(model(a, n, m != 0), "R5");
          end
        end
      end
    end

    // R4: processor strobe with primary select high is ignored
    a = 20'h3_1A2D; ext_addr = a; order_sel = 0; ctrl_strobe = 1; tick(); idle();
    check(a, "R2");
    ext_addr = 20'h0_5551; proc_strobe = 1; prim_sel_n = 1; tick(); idle();
    check(a, "R4");
    ctrl_strobe = 1; prim_sel_n = 1; ext_addr = 20'h0_5551; tick(); idle();
    check(20'h0_5551, "R2");

    // R11: restart mid-burst; a strobe wins over advance in the same cycle
    a = 20'hA_BC02; ext_addr = a; order_sel = 1; prim_sel_n = 0; proc_strobe = 1;
    tick(); idle();
    advance = 1; tick(); check(model(a, 1, 1), "R7");
    tick(); check(model(a, 2, 1), "R7");
    b = 20'h4_4443; ext_addr = b; order_sel = 0; ctrl_strobe = 1; advance = 1;
    tick(); ctrl_strobe = 0;
    check(b, "R11");
    tick(); check(model(b, 1, 0), "R11");
    tick(); check(model(b, 2, 0), "R11");
    idle(); tick(); check(model(b, 2, 0), "R5");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule